// File: doc/BRIEF.md
# Start-Up Charging Controller

This block decides when a handset with a dead main battery may draw a fixed 100 mA charge straight from a newly attached charger, and when the battery has recovered enough to let the power-up reset sequence begin. The analog parts stay outside the block: a comparator for the charger input against its detection threshold, and two comparators for the battery against an upper and a lower master-reset threshold. Each arrives as an asynchronous one-bit flag. The block drives a plain enable for the constant-current source and a level that releases the master reset to the power-up sequencer.

Charging begins only on a rising edge of the charger-detect flag, and only while the battery sits below the lower threshold. It ends when the battery passes the upper threshold, which also raises the release output. If the battery drops back under the lower threshold while charging is in progress, charging is aborted. It then resumes only after the charger flag goes low and rises again. A charger level that stays high is not enough. All three flags pass through a two-stage synchroniser before any edge or level is used. There is no data stream, so every pin is a plain control or status level.

Top module: `startup_charge_ctrl`

## Requirements
- R1: While rst_n is low, and on the first cycles after it goes high, cc_enable and rst_release are both 0, whatever the flags are.
- R2: With bat_under_lo at 1, a 0-to-1 transition of chg_detect sets cc_enable to 1. A charger already high when reset ends counts as such a transition.
- R3: An input change applied between two rising clock edges shows at the outputs after the third rising edge that follows it, and not after the second.
- R4: While charging, bat_over_hi at 1 clears cc_enable and sets rst_release.
- R5: Once rst_release is 1, it stays 1 for as long as bat_under_lo is 0, whatever chg_detect and bat_over_hi do. It returns to 0 when bat_under_lo becomes 1.
- R6: While charging, a 0-to-1 transition of bat_under_lo (the battery falling back below the lower threshold) clears cc_enable and leaves rst_release at 0.
- R7: After such an abort, chg_detect held high does not restart charging. Charging restarts only after chg_detect goes to 0 and then back to 1.
- R8: A rising edge of chg_detect while bat_under_lo is 0 and bat_over_hi is 0 leaves cc_enable at 0.
- R9: When not charging, bat_over_hi at 1 sets rst_release without ever setting cc_enable. bat_over_hi takes priority over a simultaneous charger edge.
- R10: cc_enable and rst_release are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_detect | input | 1 | Asynchronous flag: charger input above its detection threshold |
| bat_over_hi | input | 1 | Asynchronous flag: battery above the upper master-reset threshold |
| bat_under_lo | input | 1 | Asynchronous flag: battery below the lower master-reset threshold |
| cc_enable | output | 1 | Enables the 100 mA constant-current charge source |
| rst_release | output | 1 | Releases the master reset and starts the power-up sequence |

## Verification
Every result falls due on the third rising clock edge after a flag changes. Two of those edges are spent in the synchroniser, and the third loads the state register that the outputs decode. The bench changes flags only on falling edges. It then waits exactly three rising edges and samples on the next falling edge. For R3 it also samples once after only two rising edges, expecting the old outputs. Sequences that rely on edges, such as aborting and re-arming, wait the same three edges after each step before they move on.

// File: rtl/scc_pkg.sv
package scc_pkg;

  typedef enum logic [1:0] {
    SC_IDLE    = 2'd0,
    SC_CHARGE  = 2'd1,
    SC_ABORT   = 2'd2,
    SC_RELEASE = 2'd3
  } sc_state_e;

  localparam int FLAG_CHG  = 0;
  localparam int FLAG_HI   = 1;
  localparam int FLAG_LO   = 2;
  localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/scc_sync.sv
module scc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= async_in;
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign sync_out = chain[LAST];

endmodule

// File: rtl/scc_edge.sv
module scc_edge #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level[b];
      end
      assign rise[b] = level[b] & ~prev_q;
    end
  endgenerate

endmodule

// File: rtl/scc_fsm.sv
module scc_fsm
  import scc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chg_rise,
  input  logic lo_rise,
  input  logic hi_lvl,
  input  logic lo_lvl,
  output logic cc_enable,
  output logic rst_release
);

  sc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SC_IDLE, SC_ABORT: begin
        if (hi_lvl)                 state_d = SC_RELEASE;
        else if (chg_rise && lo_lvl) state_d = SC_CHARGE;
      end
      SC_CHARGE: begin
        if (hi_lvl)       state_d = SC_RELEASE;
        else if (lo_rise) state_d = SC_ABORT;
      end
      SC_RELEASE: begin
        if (lo_lvl) state_d = SC_IDLE;
      end
      default: state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SC_IDLE;
    else        state_q <= state_d;
  end

  assign cc_enable   = (state_q == SC_CHARGE);
  assign rst_release = (state_q == SC_RELEASE);

endmodule

// File: rtl/startup_charge_ctrl.sv
module startup_charge_ctrl
  import scc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chg_detect,
  input  logic bat_over_hi,
  input  logic bat_under_lo,
  output logic cc_enable,
  output logic rst_release
);

  logic [NUM_FLAGS-1:0] flags_raw;
  logic [NUM_FLAGS-1:0] flags_sync;
  logic [NUM_FLAGS-1:0] flags_rise;

  logic chg_rise_w;
  logic lo_rise_w;
  logic hi_s;
  logic lo_s;

  assign flags_raw[FLAG_CHG] = chg_detect;
  assign flags_raw[FLAG_HI]  = bat_over_hi;
  assign flags_raw[FLAG_LO]  = bat_under_lo;

  scc_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (flags_raw),
    .sync_out (flags_sync)
  );

  scc_edge #(.WIDTH(NUM_FLAGS)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (flags_sync),
    .rise  (flags_rise)
  );

  assign chg_rise_w = flags_rise[FLAG_CHG];
  assign lo_rise_w  = flags_rise[FLAG_LO];
  assign hi_s       = flags_sync[FLAG_HI];
  assign lo_s       = flags_sync[FLAG_LO];

  scc_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .chg_rise    (chg_rise_w),
    .lo_rise     (lo_rise_w),
    .hi_lvl      (hi_s),
    .lo_lvl      (lo_s),
    .cc_enable   (cc_enable),
    .rst_release (rst_release)
  );

endmodule

// File: rtl/scc_checker.sv
module scc_checker (
  input logic clk,
  input logic rst_n,
  input logic chg_rise,
  input logic lo_rise,
  input logic hi_lvl,
  input logic lo_lvl,
  input logic cc_enable,
  input logic rst_release
);

  // R10
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cc_enable && rst_release));

  // R2
  a_r2_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_enable) |-> $past(chg_rise && lo_lvl));

  // R4, R9
  a_r4_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_release) |-> $past(hi_lvl));

  // R4
  a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_enable && hi_lvl) |=> (rst_release && !cc_enable));

  // R5
  a_r5_release_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_release && !lo_lvl) |=> rst_release);

  // R6
  a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_enable && lo_rise && !hi_lvl) |=> (!cc_enable && !rst_release));

endmodule

bind startup_charge_ctrl scc_checker u_scc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .chg_rise    (chg_rise_w),
  .lo_rise     (lo_rise_w),
  .hi_lvl      (hi_s),
  .lo_lvl      (lo_s),
  .cc_enable   (cc_enable),
  .rst_release (rst_release)
);

// File: tb/startup_charge_ctrl_bench.sv
module startup_charge_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chg_detect = 1'b0;
  logic bat_over_hi = 1'b0;
  logic bat_under_lo = 1'b0;
  logic cc_enable;
  logic rst_release;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  startup_charge_ctrl u_startup_charge_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .chg_detect   (chg_detect),
    .bat_over_hi  (bat_over_hi),
    .bat_under_lo (bat_under_lo),
    .cc_enable    (cc_enable),
    .rst_release  (rst_release)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic exp_cc, input logic exp_rel);
    checks++;
    if (cc_enable !== exp_cc || rst_release !== exp_rel) begin
      fails++;
      $display("FAIL %s: cc_enable=%b rst_release=%b expected cc_enable=%b rst_release=%b",
               req, cc_enable, rst_release, exp_cc, exp_rel);
    end
    checks++;
    if (cc_enable === 1'b1 && rst_release === 1'b1) begin
      fails++;
      $display("FAIL R10: cc_enable=%b rst_release=%b expected not both 1",
               cc_enable, rst_release);
    end
  endtask

  task automatic do_reset(input logic c, input logic h, input logic l);
    @(negedge clk);
    rst_n = 1'b0;
    chg_detect = c; bat_over_hi = h; bat_under_lo = l;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic drive(input logic c, input logic h, input logic l);
    chg_detect = c; bat_over_hi = h; bat_under_lo = l;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: outputs low during reset even with the upper flag set
    @(negedge clk);
    rst_n = 1'b0;
    drive(1'b1, 1'b1, 1'b0);
    step(4);
    expect_out("R1 in reset", 1'b0, 1'b0);

    // Sweep of level combinations applied right after reset (chg starts low)
    for (int k = 0; k < 8; k++) begin
      logic c, h, l, ec, er;
      c = k[2]; h = k[1]; l = k[0];
      if (h && l) continue;
      er = h;
      ec = !h && c && l;
      do_reset(1'b0, 1'b0, 1'b0);
      expect_out("R1 after reset", 1'b0, 1'b0);
      drive(c, h, l);
      if (ec || er) begin
        step(2);
        expect_out("R3 not yet after two edges", 1'b0, 1'b0);
        step(1);
      end else begin
        step(3);
      end
      if (er)      expect_out("R9 sweep release", ec, er);
      else if (ec) expect_out("R2 sweep start", ec, er);
      else         expect_out("R8 sweep no start", ec, er);
    end

    // R2: charger already high while reset ends counts as an edge
    do_reset(1'b1, 1'b0, 1'b1);
    step(3);
    expect_out("R2 charger high at reset", 1'b1, 1'b0);

    // R9: charger edge together with upper flag goes straight to release
    do_reset(1'b0, 1'b0, 1'b1);
    step(3);
    drive(1'b1, 1'b1, 1'b0);
    step(3);
    expect_out("R9 priority over charger edge", 1'b0, 1'b1);

    // Charging, abort and re-arm sequence
    do_reset(1'b0, 1'b0, 1'b1);
    step(3);
    drive(1'b1, 1'b0, 1'b1);
    step(3);
    expect_out("R2 start", 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    step(3);
    expect_out("R2 stays on above lower threshold", 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b1);
    step(3);
    expect_out("R6 abort on fall below lower", 1'b0, 1'b0);
    step(20);
    expect_out("R7 held charger no restart", 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    step(3);
    expect_out("R7 charger low still idle", 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b1);
    step(3);
    expect_out("R7 restart on new edge", 1'b1, 1'b0);

    // R4: end of charging at the upper threshold
    drive(1'b1, 1'b0, 1'b0);
    step(3);
    drive(1'b1, 1'b1, 1'b0);
    step(2);
    expect_out("R3 release not yet", 1'b1, 1'b0);
    step(1);
    expect_out("R4 stop and release", 1'b0, 1'b1);

    // R5: release holds through charger toggles and mid band
    drive(1'b0, 1'b1, 1'b0);
    step(3);
    drive(1'b1, 1'b1, 1'b0);
    step(3);
    expect_out("R5 hold through charger edge", 1'b0, 1'b1);
    drive(1'b1, 1'b0, 1'b0);
    step(10);
    expect_out("R5 hold in mid band", 1'b0, 1'b1);
    drive(1'b1, 1'b0, 1'b1);
    step(3);
    expect_out("R5 drop below lower", 1'b0, 1'b0);
    step(10);
    expect_out("R7 held charger after drop", 1'b0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule